// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two identical, independent down-counters behind one APB-style register port. Software loads a start value, picks a count width, a clock divider and a reload behaviour, then enables the counter. Each time a counter steps from one to zero it latches a raw event flag. That flag, gated by a per-timer interrupt enable, drives the timer's own interrupt line. A write to the clear register drops the flag.

Each timer is built around a three-state controller:
- `ST_OFF`: the enable bit is low.
- `ST_RUN`: the counter steps on every prescaler tick.
- `ST_HALT`: a one-shot count has expired and the counter is parked at zero.

The transitions are:
- OFF to RUN when the enable bit is seen high.
- RUN to HALT when a one-shot counter takes a tick at one or at zero.
- HALT to RUN on a load-register write.
- Any state to OFF when the enable bit is low.

On a tick a running counter does one of four things:
- decrements;
- reloads from its stored reload value (periodic);
- wraps to the all-ones value of the selected width (free-running);
- stays at zero (one-shot).

The timer windows are 0x20 bytes apart. Address bit 5 selects the timer and bits 4:2 select the register. Within a window the registers sit at:

| Offset | Register |
|---|---|
| 0x00 | load |
| 0x04 | current value |
| 0x08 | control |
| 0x0C | clear |
| 0x10 | raw status |
| 0x14 | masked status |
| 0x18 | background load |

Top module: `dual_dtimer`

## Requirements
- R1: After reset every timer reads current value 0, control 0, raw status 0 and masked status 0, and both interrupt outputs are low.
- R2: Control bits are: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 32-bit size, bit 0 one-shot. Bit 4 and bits 31:8 read as zero. Reads of offset 0x1C, reads of offsets with address bits 1:0 non-zero, and reads with no select all return zero. Writes to offsets with address bits 1:0 non-zero are ignored.
- R3: The raw status (bit 0 of offset 0x10) becomes 1 when the counter steps from 1 to 0, whatever the interrupt enable is. It stays 1 until it is cleared.
- R4: The masked status (bit 0 of offset 0x14) and the timer's interrupt output both equal raw status AND interrupt enable.
- R5: Any write to offset 0x0C clears raw status, whatever the data written.
- R6: With bit 0 set, the counter stops at zero and stays there until the load register is written.
- R7: With bit 0 clear and bit 6 set, a tick at zero reloads the counter from the stored reload value, so the period is reload+1 ticks.
- R8: With bits 0 and 6 clear, a tick at zero wraps the counter to 0xFFFF in 16-bit size or 0xFFFFFFFF in 32-bit size.
- R9: With bit 1 clear, the counter uses and reports only the low 16 bits of the value written.
- R10: Prescale code 00 ticks on every clock, 01 on every 16th clock, 10 on every 256th clock, and 11 on every clock. The first tick comes on the second clock after the enable is written, or on the first clock after a load write to a running timer.
- R11: A load write sets both the reload value and the counter, and restarts the prescaler. A background-load write (offset 0x18) sets only the reload value, which is used at the next reload. The load offset reads back the reload value.
- R12: While the enable bit is clear the counter does not change.
- R13: The two timers are independent. Activity on one never alters the other's count, status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Byte address: bit 5 selects the timer, bits 4:2 the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read transfer |
| irq | output | 2 | Per-timer interrupt, bit i for timer i |

## Verification
A wrong controller state or counter value appears at the current-value register on the very next tick. A stuck state shows as a count that is frozen or still moving, and a wrong reload shows as a wrong value one tick after zero. A misplaced raw flag shows at the status registers and the interrupt pin in the clock after the 1-to-0 step. The bench sweeps every mode, width and prescale code on both timers and predicts each read from the number of clock edges since the start. Any off-by-one in the prescaler or in the restart timing therefore shows as a mismatch within one divider period.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } ch_state_t;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       ie;
        logic       rsv;
        logic [1:0] psc;
        logic       size32;
        logic       oneshot;
    } ctrl_t;

    localparam logic [2:0] RG_LOAD = 3'd0;
    localparam logic [2:0] RG_CUR  = 3'd1;
    localparam logic [2:0] RG_CTRL = 3'd2;
    localparam logic [2:0] RG_CLR  = 3'd3;
    localparam logic [2:0] RG_RAW  = 3'd4;
    localparam logic [2:0] RG_MIS  = 3'd5;
    localparam logic [2:0] RG_BG   = 3'd6;
endpackage

// File: rtl/dtm_prescale.sv
module dtm_prescale #(
    parameter int PRE_W    = 8,
    parameter int DIV_A_SH = 4,
    parameter int DIV_B_SH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (restart || !run)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        unique case (sel)
            2'b01:   tick = run && (&pre_q[DIV_A_SH-1:0]);
            2'b10:   tick = run && (&pre_q[DIV_B_SH-1:0]);
            default: tick = run;
        endcase
    end
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
    import dtm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PRE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_load,
    input  logic          wr_bg,
    input  logic          wr_ctrl,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] reload_o,
    output logic [DW-1:0] cur_o,
    output logic          raw_o,
    output logic          irq_o,
    output logic [1:0]    state_o,
    output logic          tick_o
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] HALF_MAX = {{(DW-HW){1'b0}}, {HW{1'b1}}};

    ctrl_t         ctrl_q;
    logic [DW-1:0] reload_q, cnt_q, wmask, cur, cnt_nx;
    logic          raw_q, run, tick;
    ch_state_t     st_q, st_nx;

    assign wmask = ctrl_q.size32 ? '1 : HALF_MAX;
    assign cur   = cnt_q & wmask;
    assign run   = (st_q == ST_RUN) && ctrl_q.en && !wr_load;

    dtm_prescale #(.PRE_W(PRE_W), .DIV_A_SH(4), .DIV_B_SH(8)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_load),
        .sel     (ctrl_q.psc),
        .tick    (tick)
    );

    // value taken on a tick
    always_comb begin
        if (cur == '0) begin
            if (ctrl_q.oneshot)       cnt_nx = '0;
            else if (ctrl_q.periodic) cnt_nx = reload_q & wmask;
            else                      cnt_nx = wmask;
        end else begin
            cnt_nx = cur - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        if (!ctrl_q.en) begin
            st_nx = ST_OFF;
        end else if (wr_load) begin
            st_nx = ST_RUN;
        end else begin
            unique case (st_q)
                ST_OFF:  st_nx = ST_RUN;
                ST_RUN:  st_nx = (tick && ctrl_q.oneshot && (cur <= 1)) ? ST_HALT : ST_RUN;
                ST_HALT: st_nx = ST_HALT;
                default: st_nx = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nx;
    end

    // datapath and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q     <= ctrl_t'(wdata[7:0]);
                ctrl_q.rsv <= 1'b0;
            end
            if (wr_load || wr_bg)
                reload_q <= wdata;
            if (wr_load)
                cnt_q <= wdata & wmask;
            else if (tick)
                cnt_q <= cnt_nx;
            if (wr_clr)
                raw_q <= 1'b0;
            if (tick && (cur == 1))
                raw_q <= 1'b1;
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign cur_o    = cur;
    assign raw_o    = raw_q;
    assign irq_o    = raw_q & ctrl_q.ie;
    assign state_o  = st_q;
    assign tick_o   = tick;
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
    import dtm_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int DW     = 32,
    parameter int PRE_W  = 8,
    parameter int WIN_SH = 5,
    parameter int AW     = WIN_SH + ((N_TMR > 1) ? $clog2(N_TMR) : 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    output logic [N_TMR-1:0] irq
);
    localparam int TSEL_W = AW - WIN_SH;

    logic [TSEL_W-1:0] tsel;
    logic [2:0]        rsel;
    logic              aligned, wr_go, rd_go;

    logic [N_TMR-1:0]         wr_load, wr_bg, wr_ctrl, wr_clr;
    logic [N_TMR-1:0]         raw_a, tick_a, en_a;
    logic [N_TMR-1:0][DW-1:0] cur_a, reload_a;
    logic [N_TMR-1:0][1:0]    st_a;
    ctrl_t                    ctrl_a [N_TMR];

    assign tsel    = paddr[AW-1:WIN_SH];
    assign rsel    = paddr[4:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_go   = psel && penable && pwrite && aligned;
    assign rd_go   = psel && !pwrite && aligned;

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic hit;
        assign hit        = wr_go && (tsel == TSEL_W'(i));
        assign wr_load[i] = hit && (rsel == RG_LOAD);
        assign wr_ctrl[i] = hit && (rsel == RG_CTRL);
        assign wr_clr[i]  = hit && (rsel == RG_CLR);
        assign wr_bg[i]   = hit && (rsel == RG_BG);
        assign en_a[i]    = ctrl_a[i].en;

        dtm_channel #(.DW(DW), .PRE_W(PRE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_load  (wr_load[i]),
            .wr_bg    (wr_bg[i]),
            .wr_ctrl  (wr_ctrl[i]),
            .wr_clr   (wr_clr[i]),
            .wdata    (pwdata),
            .ctrl_o   (ctrl_a[i]),
            .reload_o (reload_a[i]),
            .cur_o    (cur_a[i]),
            .raw_o    (raw_a[i]),
            .irq_o    (irq[i]),
            .state_o  (st_a[i]),
            .tick_o   (tick_a[i])
        );
    end

    always_comb begin
        prdata = '0;
        if (rd_go) begin
            unique case (rsel)
                RG_LOAD, RG_BG: prdata = reload_a[tsel];
                RG_CUR:         prdata = cur_a[tsel];
                RG_CTRL:        prdata = DW'(ctrl_a[tsel]);
                RG_RAW:         prdata = DW'(raw_a[tsel]);
                RG_MIS:         prdata = DW'(irq[tsel]);
                default:        prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
    parameter int N  = 2,
    parameter int DW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         ld_wr,
    input logic [N-1:0]         ctrl_wr,
    input logic [N-1:0]         clr_wr,
    input logic [N-1:0]         tick,
    input logic [N-1:0]         raw,
    input logic [N-1:0]         en,
    input logic [N-1:0][DW-1:0] cur,
    input logic [N-1:0][1:0]    st
);
    localparam logic [1:0] S_RUN  = 2'd1;
    localparam logic [1:0] S_HALT = 2'd2;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_RAW_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == S_RUN && tick[i] && cur[i] == 1 && !ld_wr[i]) |=> raw[i]); // R3
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr[i] && !(tick[i] && cur[i] == 1)) |=> !raw[i]); // R5
        AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == S_HALT && !ld_wr[i]) |=> (cur[i] == '0)); // R6
        AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !ld_wr[i] && !ctrl_wr[i]) |=> $stable(cur[i])); // R12
        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[i] && !ld_wr[i] && !ctrl_wr[i] && cur[i] > 1) |=> (cur[i] == $past(cur[i]) - 1)); // R10
    end
endmodule

bind dual_dtimer dtm_checker #(.N(N_TMR), .DW(DW)) u_dtm_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_wr   (wr_load),
    .ctrl_wr (wr_ctrl),
    .clr_wr  (wr_clr),
    .tick    (tick_a),
    .raw     (raw_a),
    .en      (en_a),
    .cur     (cur_a),
    .st      (st_a)
);

// File: tb/dual_dtimer_bench.sv
module dual_dtimer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  irq;

    int unsigned cyc = 0;
    int          nchk = 0, nbad = 0;

    dual_dtimer u_dual_dtimer (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int unsigned last_wr;
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d,
                      output int unsigned at, output logic [1:0] iq);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata; at = cyc; iq = irq;
        psel = 1'b0;
    endtask

    function automatic logic [31:0] exp_cnt(input int mode, input logic [31:0] l,
                                            input logic [31:0] msk, input int unsigned t);
        if (mode == 0)      return (t >= l) ? 32'd0 : l - t;
        else if (mode == 1) return l - 32'(t % (l + 1));
        else                return (l - t) & msk;
    endfunction

    task automatic run_all();
        logic [31:0] d, d2;
        int unsigned at;
        logic [1:0] iq;
        // R1 reset state
        for (int tm = 0; tm < 2; tm++) begin
            rd(6'(tm*32 + 4), d, at, iq);    chk("R1 cur", d, 0);
            rd(6'(tm*32 + 8), d, at, iq);    chk("R1 ctrl", d, 0);
            rd(6'(tm*32 + 16), d, at, iq);   chk("R1 raw", d, 0);
            rd(6'(tm*32 + 20), d, at, iq);   chk("R1 masked", d, 0);
            chk("R1 irq", 32'(iq), 0);
        end
        // sweep: timer x mode x size x prescale
        for (int tm = 0; tm < 2; tm++)
        for (int mode = 0; mode < 3; mode++)
        for (int sz = 0; sz < 2; sz++)
        for (int ps = 0; ps < 4; ps++) begin
            logic [5:0] b, ob;
            logic [31:0] l, lm, msk, oth;
            logic [7:0] c;
            int unsigned div, start, t;
            logic ie, rexp;
            string tag;
            b = 6'(tm*32); ob = 6'((1-tm)*32);
            l = sz ? 32'd5 : 32'h0003_0004;
            msk = sz ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            lm = l & msk;
            div = (ps == 1) ? 16 : (ps == 2) ? 256 : 1;
            ie = ps[0];
            tag = (mode == 0) ? "R6" : (mode == 1) ? "R7" : "R8";
            wr(b + 8, 0); wr(ob + 8, 0);
            wr(b + 12, 32'hDEAD_BEEF); wr(ob + 12, 32'h0);
            wr(b + 0, l);
            rd(ob + 4, oth, at, iq);
            c = {1'b1, (mode == 1), ie, 1'b0, 2'(ps), 1'(sz), (mode == 0)};
            wr(b + 8, {24'h0, c});
            start = last_wr + 1;
            for (int s = 0; s < 10; s++) begin
                repeat (div) @(negedge clk);
                rd(b + 4, d, at, iq);
                t = (at - start) / div;
                chk($sformatf("%s/R9/R10 cur m%0d s%0d p%0d", tag, mode, sz, ps), d, exp_cnt(mode, lm, msk, t));
                rd(b + 16, d, at, iq);
                t = (at - start) / div;
                rexp = (t >= lm);
                chk("R3 raw", d, 32'(rexp));
                rd(b + 20, d, at, iq);
                t = (at - start) / div;
                rexp = (t >= lm) && ie;
                chk("R4 masked", d, 32'(rexp));
                chk("R4 irq", 32'(iq[tm]), 32'(rexp));
            end
            rd(ob + 4, d, at, iq);  chk("R13 other cur", d, oth);
            rd(ob + 16, d, at, iq); chk("R13 other raw", d, 0);
            chk("R13 other irq", 32'(iq[1-tm]), 0);
        end
        wr(6'd8, 0); wr(6'd40, 0); wr(6'd12, 0); wr(6'd44, 0);
        // R2 control layout, unmapped and unaligned
        wr(6'd40, 32'h0000_003F); rd(6'd40, d, at, iq); chk("R2 ctrl rsv", d, 32'h2F);
        wr(6'd40, 32'hFFFF_FF50); rd(6'd40, d, at, iq); chk("R2 ctrl high", d, 32'h40);
        rd(6'd28, d, at, iq); chk("R2 unmapped t0", d, 0);
        rd(6'd60, d, at, iq); chk("R2 unmapped t1", d, 0);
        wr(6'd32, 32'd77); wr(6'd33, 32'd99);
        rd(6'd32, d, at, iq); chk("R2 unaligned wr", d, 77);
        rd(6'd36, d, at, iq); chk("R2 unaligned wr cur", d, 77);
        rd(6'd37, d, at, iq); chk("R2 unaligned rd", d, 0);
        wr(6'd40, 0);
        // R5 / R6 one-shot, clear
        wr(6'd0, 3); wr(6'd12, 0); wr(6'd8, 32'hA3);
        repeat (20) @(negedge clk);
        rd(6'd4, d, at, iq);  chk("R6 stopped", d, 0);
        chk("R4 irq oneshot", 32'(iq[0]), 1);
        rd(6'd16, d, at, iq); chk("R3 raw oneshot", d, 1);
        wr(6'd12, 32'h0);
        rd(6'd16, d, at, iq); chk("R5 raw cleared", d, 0);
        chk("R5 irq cleared", 32'(iq[0]), 0);
        repeat (5) @(negedge clk);
        rd(6'd4, d, at, iq);  chk("R6 still zero", d, 0);
        rd(6'd16, d, at, iq); chk("R6 no new event", d, 0);
        wr(6'd0, 2);
        rd(6'd4, d, at, iq);  chk("R11 restart from halt", d, 2 - (at - last_wr));
        // R11 background load and restart
        wr(6'd8, 0); wr(6'd0, 20); wr(6'd12, 0); wr(6'd8, 32'hC2);
        begin
            int unsigned st0, t;
            st0 = last_wr + 1;
            wr(6'd24, 3);
            rd(6'd4, d, at, iq); t = at - st0;
            chk("R11 bg keeps count", d, 20 - t);
            rd(6'd0, d, at, iq); chk("R11 reload readback", d, 3);
            repeat (18) @(negedge clk);
            for (int s = 0; s < 6; s++) begin
                rd(6'd4, d, at, iq); t = at - st0;
                chk("R11 bg used at reload", d, (t <= 20) ? 20 - t : 3 - ((t - 21) % 4));
                repeat (2) @(negedge clk);
            end
            wr(6'd0, 50);
            rd(6'd4, d, at, iq); chk("R11 load restarts", d, 50 - (at - last_wr));
        end
        // R12 frozen while disabled
        wr(6'd8, 32'h42);
        rd(6'd4, d, at, iq); repeat (10) @(negedge clk);
        rd(6'd4, d2, at, iq); chk("R12 frozen", d2, d);
        wr(6'd0, 7);
        rd(6'd4, d, at, iq); chk("R11 load while off", d, 7);
        repeat (5) @(negedge clk);
        rd(6'd4, d, at, iq); chk("R12 still 7", d, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nbad++; nchk++;
                $display("FAIL watchdog R1 actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule